// File: doc/BRIEF.md
# Weight-Programmable Two-Input Threshold Gate

This block is a single artificial neuron that behaves as a two-input Boolean gate. Each accepted input pair is multiplied by two signed fixed-point weights. The products are summed with a signed bias, and the sum passes through a clamped linear ramp. The result is an 8-bit confidence level and a one-bit decision. The datapath is the same for every gate. Only the loaded weights and bias decide whether the block computes AND, NAND, OR, NOR or a single-input inverter.

Software or a sequencer configures the block in one of two ways. It can write an arbitrary weight pair and bias, or it can request one of five built-in presets. It then streams operand pairs with a valid strobe. Each accepted pair produces a registered result one cycle later.

Top module: `nrn_gate`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_level` and `out_bit` are driven low at each clock edge, and the weight registers take the AND preset.
- R2: A `preset_we` pulse with code `preset_sel` loads fixed weights and bias, written as raw Q1.8 integers in units of 1/256:
  - 0 = AND: w0 123, w1 123, bias -185
  - 1 = NAND: w0 -100, w1 -177, bias 227
  - 2 = OR: w0 251, w1 225, bias -112
  - 3 = NOR: w0 -251, w1 -225, bias 112
  - 4 = NOT: w0 -256, w1 0, bias 128
- R3: A `preset_we` pulse with `preset_sel` of 5, 6 or 7 leaves the weights and bias unchanged.
- R4: `cfg_we` loads `cfg_w0`, `cfg_w1` and `cfg_bias` directly. When `cfg_we` and `preset_we` are both high, the direct load wins.
- R5: The pre-activation sum is w0·in_a + w1·in_b + bias, taken as signed integers in units of 1/256.
- R6: `out_level` = clamp(4·sum + 128, 0, 255).
- R7: `out_bit` is 1 exactly when `out_level` is at least 128, which is the same as sum ≥ 0.
- R8: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. `out_level` and `out_bit` hold their value when no input is accepted.
- R9: A weight load takes effect on inputs accepted in later cycles. An input accepted in the same cycle as a load uses the previous weights.
- R10: With each preset loaded, all four input pairs give the gate's truth table, with `out_level` 255 for true and 0 for false.
- R11: In the NOT preset the result is the inverse of `in_a`, and `in_b` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Direct weight and bias load strobe |
| cfg_w0 | input | WW (10) | Signed Q1.8 weight for in_a |
| cfg_w1 | input | WW (10) | Signed Q1.8 weight for in_b |
| cfg_bias | input | BW (10) | Signed Q1.8 bias |
| preset_we | input | 1 | Preset load strobe |
| preset_sel | input | 3 | Preset code (0 AND, 1 NAND, 2 OR, 3 NOR, 4 NOT) |
| in_valid | input | 1 | Operand pair valid |
| in_a | input | 1 | First operand |
| in_b | input | 1 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_level | output | LW (8) | Activation level, unsigned fraction of 256 |
| out_bit | output | 1 | Thresholded binary result |

## Verification
The hardest case to reach from the ports is the middle of the ramp, where `out_level` lies strictly between 0 and 255. None of the presets lands there. The stimulus writes small custom weights, such as w0 = 10 or w0 = -1 with zero bias, to reach levels 168, 128 and 124 and test the threshold edge exactly. The load-ordering cases are driven on purpose:
- a preset load in the same cycle as a valid input;
- a reserved preset code;
- a direct load and a preset load together.

Each of these is followed immediately by an input whose result would differ under the wrong weights.

// File: rtl/nrn_gate_pkg.sv
package nrn_gate_pkg;

    // Preset codes; weights are raw Q1.8 integers (units of 1/256)
    typedef enum logic [2:0] {
        GATE_AND  = 3'd0,
        GATE_NAND = 3'd1,
        GATE_OR   = 3'd2,
        GATE_NOR  = 3'd3,
        GATE_NOT  = 3'd4
    } gate_sel_e;

    localparam int FRAC_BITS = 8;

    typedef struct packed {
        logic        ok;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] bias;
    } preset_t;

    function automatic preset_t preset_of(logic [2:0] sel);
        preset_t p;
        p.ok = 1'b1;
        case (sel)
            GATE_AND:  begin p.w0 = 32'( 123); p.w1 = 32'( 123); p.bias = 32'(-185); end
            GATE_NAND: begin p.w0 = 32'(-100); p.w1 = 32'(-177); p.bias = 32'( 227); end
            GATE_OR:   begin p.w0 = 32'( 251); p.w1 = 32'( 225); p.bias = 32'(-112); end
            GATE_NOR:  begin p.w0 = 32'(-251); p.w1 = 32'(-225); p.bias = 32'( 112); end
            GATE_NOT:  begin p.w0 = 32'(-256); p.w1 = 32'(   0); p.bias = 32'( 128); end
            default:   begin p.ok = 1'b0; p.w0 = '0; p.w1 = '0; p.bias = '0; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/nrn_wreg.sv
module nrn_wreg
    import nrn_gate_pkg::*;
#(
    parameter int WW = 10,
    parameter int BW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic signed [WW-1:0] cfg_w0,
    input  logic signed [WW-1:0] cfg_w1,
    input  logic signed [BW-1:0] cfg_bias,
    input  logic                 preset_we,
    input  logic [2:0]           preset_sel,
    output logic signed [WW-1:0] w0,
    output logic signed [WW-1:0] w1,
    output logic signed [BW-1:0] bias
);
    preset_t pre_sel;
    preset_t pre_rst;

    always_comb begin
        pre_sel = preset_of(preset_sel);
        pre_rst = preset_of(GATE_AND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w0   <= WW'(pre_rst.w0);
            w1   <= WW'(pre_rst.w1);
            bias <= BW'(pre_rst.bias);
        end else if (cfg_we) begin
            w0   <= cfg_w0;
            w1   <= cfg_w1;
            bias <= cfg_bias;
        end else if (preset_we && pre_sel.ok) begin
            w0   <= WW'(pre_sel.w0);
            w1   <= WW'(pre_sel.w1);
            bias <= BW'(pre_sel.bias);
        end
    end
endmodule

// File: rtl/nrn_mac.sv
module nrn_mac #(
    parameter int WW = 10,
    parameter int BW = 10,
    parameter int SW = 12
) (
    input  logic                 in_a,
    input  logic                 in_b,
    input  logic signed [WW-1:0] w0,
    input  logic signed [WW-1:0] w1,
    input  logic signed [BW-1:0] bias,
    output logic signed [SW-1:0] sum
);
    logic signed [SW-1:0] t0, t1, tb;

    always_comb begin
        t0  = in_a ? SW'(w0) : '0;
        t1  = in_b ? SW'(w1) : '0;
        tb  = SW'(bias);
        sum = t0 + t1 + tb;
    end
endmodule

// File: rtl/nrn_act.sv
module nrn_act #(
    parameter int SW      = 12,
    parameter int LW      = 8,
    parameter int GAIN_SH = 2
) (
    input  logic signed [SW-1:0] sum,
    output logic [LW-1:0]        level,
    output logic                 decision
);
    localparam int PW   = SW + GAIN_SH + 1;
    localparam int MID  = 2 ** (LW - 1);
    localparam int MAXV = 2 ** LW - 1;

    logic signed [PW-1:0] pre;

    always_comb begin
        pre = (PW'(sum) <<< GAIN_SH) + PW'(MID);
        if (pre < 0)
            level = '0;
        else if (pre > PW'(MAXV))
            level = LW'(MAXV);
        else
            level = pre[LW-1:0];
        decision = level[LW-1];
    end
endmodule

// File: rtl/nrn_gate.sv
module nrn_gate
    import nrn_gate_pkg::*;
#(
    parameter int WW      = 10,
    parameter int BW      = 10,
    parameter int LW      = 8,
    parameter int GAIN_SH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic signed [WW-1:0] cfg_w0,
    input  logic signed [WW-1:0] cfg_w1,
    input  logic signed [BW-1:0] cfg_bias,
    input  logic                 preset_we,
    input  logic [2:0]           preset_sel,
    input  logic                 in_valid,
    input  logic                 in_a,
    input  logic                 in_b,
    output logic                 out_valid,
    output logic [LW-1:0]        out_level,
    output logic                 out_bit
);
    localparam int SW = ((WW > BW) ? WW : BW) + 2;

    logic signed [WW-1:0] w0, w1;
    logic signed [BW-1:0] bias;
    logic signed [SW-1:0] sum;
    logic [LW-1:0]        level;
    logic                 decision;

    nrn_wreg #(.WW(WW), .BW(BW)) u_wreg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_w0(cfg_w0), .cfg_w1(cfg_w1), .cfg_bias(cfg_bias),
        .preset_we(preset_we), .preset_sel(preset_sel),
        .w0(w0), .w1(w1), .bias(bias)
    );

    nrn_mac #(.WW(WW), .BW(BW), .SW(SW)) u_mac (
        .in_a(in_a), .in_b(in_b), .w0(w0), .w1(w1), .bias(bias), .sum(sum)
    );

    nrn_act #(.SW(SW), .LW(LW), .GAIN_SH(GAIN_SH)) u_act (
        .sum(sum), .level(level), .decision(decision)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_level <= '0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_level <= level;
                out_bit   <= decision;
            end
        end
    end
endmodule

// File: rtl/nrn_gate_chk.sv
module nrn_gate_chk #(
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [LW-1:0] out_level,
    input logic          out_bit
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_level == '0 && !out_bit));

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_level) && $stable(out_bit)));

    // R7
    thresh_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bit == (out_level >= LW'(1 << (LW - 1)))));
endmodule

bind nrn_gate nrn_gate_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .out_level(out_level), .out_bit(out_bit)
);

// File: tb/test_nrn_gate.sv
module test_nrn_gate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic signed [9:0] cfg_w0 = '0, cfg_w1 = '0, cfg_bias = '0;
    logic preset_we = 1'b0;
    logic [2:0] preset_sel = '0;
    logic in_valid = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic out_valid;
    logic [7:0] out_level;
    logic out_bit;

    int total = 0, bad = 0;
    int m_w0 = 123, m_w1 = 123, m_b = -185;
    int e_valid = 0, e_level = 0, e_bit = 0;

    always #4 clk = ~clk;

    nrn_gate i_nrn_gate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_w0(cfg_w0), .cfg_w1(cfg_w1),
        .cfg_bias(cfg_bias), .preset_we(preset_we), .preset_sel(preset_sel),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_level(out_level), .out_bit(out_bit)
    );

    function automatic int ref_level(int w0, int w1, int b, logic a, logic bb);
        int s = (a ? w0 : 0) + (bb ? w1 : 0) + b;
        int p = 4 * s + 128;
        if (p < 0) return 0;
        if (p > 255) return 255;
        return p;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // one clock: predict, advance model, sample after edge
    task automatic tick();
        if (rst) begin
            e_valid = 0; e_level = 0; e_bit = 0;
        end else begin
            e_valid = in_valid;
            if (in_valid) begin
                e_level = ref_level(m_w0, m_w1, m_b, in_a, in_b);
                e_bit   = (e_level >= 128);
            end
        end
        if (rst) begin
            m_w0 = 123; m_w1 = 123; m_b = -185;
        end else if (cfg_we) begin
            m_w0 = cfg_w0; m_w1 = cfg_w1; m_b = cfg_bias;
        end else if (preset_we) begin
            case (preset_sel)
                3'd0: begin m_w0 = 123;  m_w1 = 123;  m_b = -185; end
                3'd1: begin m_w0 = -100; m_w1 = -177; m_b = 227;  end
                3'd2: begin m_w0 = 251;  m_w1 = 225;  m_b = -112; end
                3'd3: begin m_w0 = -251; m_w1 = -225; m_b = 112;  end
                3'd4: begin m_w0 = -256; m_w1 = 0;    m_b = 128;  end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk("R8 out_valid", out_valid, e_valid);
        chk("R6 out_level", out_level, e_level);
        chk("R7 out_bit", out_bit, e_bit);
        cfg_we = 0; preset_we = 0; in_valid = 0;
    endtask

    task automatic load_preset(int sel);
        preset_we = 1; preset_sel = 3'(sel);
        tick();
    endtask

    task automatic load_cfg(int w0, int w1, int b);
        cfg_we = 1; cfg_w0 = 10'(w0); cfg_w1 = 10'(w1); cfg_bias = 10'(b);
        tick();
    endtask

    task automatic apply(logic a, logic b);
        in_valid = 1; in_a = a; in_b = b;
        tick();
    endtask

    function automatic int truth(int sel, logic a, logic b);
        case (sel)
            0: return int'(a & b);
            1: return int'(!(a & b));
            2: return int'(a | b);
            3: return int'(!(a | b));
            default: return int'(!a);
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) tick();
        // R1 reset state
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset level", out_level, 0);
        rst = 0;
        tick();
        // R1 weights are AND after reset
        apply(1, 1);
        chk("R1 AND after reset", out_level, 255);
        apply(1, 0);
        chk("R1 AND after reset", out_level, 0);

        // R2 / R10 / R11 preset truth tables
        for (int sel = 0; sel < 5; sel++) begin
            load_preset(sel);
            for (int v = 0; v < 4; v++) begin
                logic a = v[1], b = v[0];
                apply(a, b);
                chk(sel == 4 ? "R11 NOT table" : "R10 truth table",
                    out_level, truth(sel, a, b) ? 255 : 0);
                chk("R2 preset bit", out_bit, truth(sel, a, b));
            end
        end
        // R11: in_b toggled under NOT with in_a fixed
        apply(1, 0);
        chk("R11 NOT ignores in_b", out_level, 0);
        apply(1, 1);
        chk("R11 NOT ignores in_b", out_level, 0);

        // R3 reserved codes
        load_preset(3);
        load_preset(6);
        apply(0, 0);
        chk("R3 reserved code ignored", out_level, 255);
        load_preset(7);
        apply(1, 0);
        chk("R3 reserved code ignored", out_level, 0);

        // R9 same-cycle load uses old weights (NOR now, AND requested)
        preset_we = 1; preset_sel = 3'd0;
        apply(1, 1);
        chk("R9 old weights same cycle", out_level, 0);
        apply(1, 1);
        chk("R9 new weights next", out_level, 255);

        // R4 cfg wins over preset
        cfg_we = 1; cfg_w0 = 10'sd256; cfg_w1 = 10'sd0; cfg_bias = -10'sd128;
        preset_we = 1; preset_sel = 3'd2;
        tick();
        apply(0, 1);
        chk("R4 direct load priority", out_level, 0);
        apply(1, 1);
        chk("R4 direct load value", out_level, 255);

        // R5 / R6 / R7 mid ramp and threshold edge
        load_cfg(10, 0, 0);
        apply(1, 0);
        chk("R6 mid ramp", out_level, 168);
        apply(0, 1);
        chk("R7 boundary level", out_level, 128);
        chk("R7 boundary bit", out_bit, 1);
        load_cfg(-1, 5, 0);
        apply(1, 0);
        chk("R7 below threshold", out_level, 124);
        chk("R7 below threshold bit", out_bit, 0);
        apply(1, 1);
        chk("R5 both weights summed", out_level, 144);

        // R8 hold with idle cycles
        tick();
        chk("R8 hold level", out_level, 144);

        // random traffic against model
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            if (r == 0) begin
                cfg_we = 1;
                cfg_w0 = 10'($urandom); cfg_w1 = 10'($urandom); cfg_bias = 10'($urandom);
            end else if (r == 1) begin
                preset_we = 1; preset_sel = 3'($urandom);
            end
            in_valid = ($urandom_range(0, 3) != 0);
            in_a = 1'($urandom); in_b = 1'($urandom);
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule